// File: doc/BRIEF.md
# Transmit Dominant Guard

This block sits between a CAN protocol controller's transmit output and the bus driver of the line interface. It decides, every clock cycle, whether the driver may pull the bus dominant. The transmit input is active low: low requests a dominant bit and high leaves the bus recessive. If the transmit line is left open, it is read as high.

Two faults can take the driver off the bus. The first is a transmit line that stays low for longer than a timeout, which would otherwise block all traffic on the bus. The second is an over-temperature indication from the analog side. Each fault sets its own status flag. Neither flag clears after a delay: each one waits for the transmit line to return high. Standby and a supply below the power-on level also keep the driver off, but they leave both flags as they are.

The transmit and over-temperature inputs are plain asynchronous levels, not a data stream. For that reason the block has no valid/ready handshake. Both inputs pass through synchronizer chains before any logic uses them.

Top module: `tx_dom_guard`

## Requirements
- R1: `drv_dom` is high only when `drv_en` is high and the synchronized transmit level is low. The transmit level reaches the logic SYNC_STAGES cycles after `txd_in` changes. Low means dominant.
- R2: While `txd_open` is 1, the transmit input reads as high whatever `txd_in` is, so `drv_dom` stays 0.
- R3: The synchronized transmit level may be low for TMO_CYC consecutive samples. At the end of the sample that completes this run, `tmo_fault` goes to 1 and `drv_en` goes to 0.
- R4: A low run shorter than TMO_CYC samples never sets `tmo_fault`. A high sample restarts the run, so two short low runs separated by a high never add together.
- R5: `tmo_fault` stays at 1 for as long as the transmit level stays low. It clears on the first rising edge of the synchronized transmit level.
- R6: A low run far longer than TMO_CYC keeps `tmo_fault` at 1 and `drv_dom` at 0 for the whole run. The dominant counter saturates and never wraps.
- R7: A synchronized over-temperature level of 1 sets `therm_fault` and forces `drv_en` to 0. The dominant timer keeps running while `therm_fault` is set.
- R8: Once the over-temperature input drops, `therm_fault` stays at 1. It clears only on a rising edge of the synchronized transmit level that arrives while the synchronized over-temperature level is 0.
- R9: `standby` = 1 or `pwr_ok` = 0 forces `drv_en` and `drv_dom` to 0 in the same cycle. Neither input changes `tmo_fault` or `therm_fault`.
- R10: After reset, `tmo_fault` and `therm_fault` are 0, and the transmit level reads as high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd_in | input | 1 | Transmit data from the controller, low = dominant |
| txd_open | input | 1 | 1 when the transmit input is unconnected |
| over_temp | input | 1 | Digital over-temperature indication |
| standby | input | 1 | Low-power mode select, driver off when 1 |
| pwr_ok | input | 1 | Supply above power-on level |
| drv_en | output | 1 | Driver allowed to drive |
| drv_dom | output | 1 | Drive the bus dominant |
| tmo_fault | output | 1 | Dominant timeout fault |
| therm_fault | output | 1 | Latched thermal fault |

## Verification
The embedded properties check on every cycle that the counter never passes its limit and that a timeout appears only when the counter has reached it. They also check that each fault flag holds until a rising transmit edge and then clears, and that neither fault coexists with a dominant drive. Only the bench scenarios can show the exact cycle at which a timeout lands after the synchronizer delay. The same holds for the result of a short low run, for an over-temperature level still present when the transmit line rises, and for the open-input and standby cases, all of which the bench observes at the ports.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

  // counter width able to hold the value lim
  function automatic int unsigned tdg_cnt_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // synchronized view of the asynchronous control pins
  typedef struct packed {
    logic txd;
    logic hot;
  } tdg_pins_t;

endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tdg_edge.sv
module tdg_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= sig;
  end

  assign rise = sig & ~prev;
  assign fall = ~sig & prev;

  // R5: an edge is a single-cycle event
  a_r5_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tdg_dom_timer.sv
module tdg_dom_timer #(
  parameter int unsigned TMO_CYC = 81250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s,
  input  logic fall,
  input  logic rise,
  output logic tmo_flag
);
  import tdg_pkg::*;

  localparam int unsigned CW = tdg_cnt_w(TMO_CYC);
  localparam logic [CW-1:0] LIM  = CW'(TMO_CYC);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  // low-run counter: started by a falling edge, cleared while high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (fall)       cnt <= ONE;
    else if (txd_s)      cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     tmo_flag <= 1'b0;
    else if (rise)                  tmo_flag <= 1'b0;
    else if (!txd_s && cnt == LAST) tmo_flag <= 1'b1;
  end

  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);
  a_r3_set_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> cnt == LIM);
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> cnt == ONE);
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !txd_s |=> tmo_flag);
  a_r5_clear_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !tmo_flag);

endmodule

// File: rtl/tdg_therm_latch.sv
module tdg_therm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_s,
  input  logic rise,
  output logic therm_flag
);

  // set has priority over the release edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     therm_flag <= 1'b0;
    else if (hot_s) therm_flag <= 1'b1;
    else if (rise)  therm_flag <= 1'b0;
  end

  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |=> therm_flag);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flag && !rise |=> therm_flag);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    rise && !hot_s |=> !therm_flag);

endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard #(
  parameter int unsigned TMO_CYC     = 81250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic txd_open,
  input  logic over_temp,
  input  logic standby,
  input  logic pwr_ok,
  output logic drv_en,
  output logic drv_dom,
  output logic tmo_fault,
  output logic therm_fault
);
  import tdg_pkg::*;

  tdg_pins_t pins;
  logic      txd_raw;
  logic      tx_rise;
  logic      tx_fall;

  // an open input reads as recessive
  assign txd_raw = txd_in | txd_open;

  tdg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_tx (
    .clk(clk), .rst_n(rst_n), .d(txd_raw), .q(pins.txd));

  tdg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hot (
    .clk(clk), .rst_n(rst_n), .d(over_temp), .q(pins.hot));

  tdg_edge #(.IDLE(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig(pins.txd), .rise(tx_rise), .fall(tx_fall));

  tdg_dom_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .txd_s(pins.txd), .fall(tx_fall),
    .rise(tx_rise), .tmo_flag(tmo_fault));

  tdg_therm_latch u_therm (
    .clk(clk), .rst_n(rst_n), .hot_s(pins.hot), .rise(tx_rise),
    .therm_flag(therm_fault));

  assign drv_en  = pwr_ok & ~standby & ~tmo_fault & ~therm_fault;
  assign drv_dom = drv_en & ~pins.txd;

  a_r3_timeout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fault |-> !drv_dom);
  a_r7_hot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    therm_fault |-> !drv_dom);
  a_r1_dom_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom |-> !tx_rise);

endmodule

// File: tb/sim_tx_dom_guard.sv
`timescale 1ns/1ps
module sim_tx_dom_guard;

  localparam int TMO  = 20;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_in = 1'b1, txd_open = 1'b0, over_temp = 1'b0;
  logic standby = 1'b0, pwr_ok = 1'b1;
  logic drv_en, drv_dom, tmo_fault, therm_fault;

  int total = 0;
  int bad = 0;
  int wd = 0;
  string req = "R10";

  always #4 clk = ~clk;

  tx_dom_guard #(.TMO_CYC(TMO), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .txd_open(txd_open),
    .over_temp(over_temp), .standby(standby), .pwr_ok(pwr_ok),
    .drv_en(drv_en), .drv_dom(drv_dom), .tmo_fault(tmo_fault),
    .therm_fault(therm_fault));

  // reference model: pushes expected {en,dom,tmo,th} once per cycle
  logic [SYNC-1:0] m_tx;
  logic [SYNC-1:0] m_ot;
  logic m_prev, m_tmo, m_th;
  int   m_run;
  logic [3:0] q_exp[$];
  string q_tag[$];

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_tx = '1; m_ot = '0; m_prev = 1'b1; m_tmo = 1'b0; m_th = 1'b0; m_run = 0;
    end else begin
      logic s, o, up, en;
      s  = m_tx[SYNC-1];
      o  = m_ot[SYNC-1];
      up = s && !m_prev;
      m_run = s ? 0 : m_run + 1;
      if (up)                      m_tmo = 1'b0;
      else if (!s && m_run >= TMO) m_tmo = 1'b1;
      if (o)       m_th = 1'b1;
      else if (up) m_th = 1'b0;
      m_prev = s;
      m_tx = {m_tx[SYNC-2:0], txd_in | txd_open};
      m_ot = {m_ot[SYNC-2:0], over_temp};
      en = pwr_ok && !standby && !m_tmo && !m_th;
      q_exp.push_back({en, en && !m_tx[SYNC-1], m_tmo, m_th});
      q_tag.push_back(req);
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act en/dom/tmo/th=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: scoreboard comparison
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [3:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(t, {drv_en, drv_dom, tmo_fault, therm_fault}, e);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait n posedges, sample 2ns later
  task automatic at_post(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    chk("R10", {drv_en, drv_dom, tmo_fault, therm_fault}, 4'b1000);
    cyc(4);

    // R1: fast toggling passes through
    req = "R1";
    for (int i = 0; i < 6; i++) begin txd_in = i[0]; cyc(3); end
    txd_in = 1'b1; cyc(4);

    // R2: open input reads recessive
    req = "R2";
    txd_open = 1'b1; txd_in = 1'b0; cyc(TMO + 8);
    chk("R2", {drv_dom, tmo_fault}, 4'b0);
    txd_open = 1'b0; txd_in = 1'b1; cyc(4);

    // R4: two short low runs do not accumulate
    req = "R4";
    txd_in = 1'b0; cyc(TMO - 2); txd_in = 1'b1; cyc(1);
    txd_in = 1'b0; cyc(TMO - 2); txd_in = 1'b1; cyc(4);
    chk("R4", {3'b0, tmo_fault}, 4'b0);

    // R3: exact timeout cycle
    req = "R3";
    txd_in = 1'b0;
    at_post(SYNC + TMO - 1);
    chk("R3", {2'b0, drv_dom, tmo_fault}, 4'b0010);
    at_post(1);
    chk("R3", {2'b0, drv_en, tmo_fault}, 4'b0001);
    // R6: long hold, still off
    req = "R6";
    cyc(3 * TMO);
    chk("R6", {2'b0, drv_dom, tmo_fault}, 4'b0001);
    // R5: release by rising edge
    req = "R5";
    @(negedge clk); txd_in = 1'b1;
    at_post(SYNC + 1);
    chk("R5", {3'b0, tmo_fault}, 4'b0);
    cyc(3);

    // R7/R8: thermal flag latched, cleared by edge after cooling
    req = "R7";
    over_temp = 1'b1; cyc(4);
    req = "R8";
    over_temp = 1'b0; cyc(6);
    chk("R8", {3'b0, therm_fault}, 4'b0001);
    txd_in = 1'b0; cyc(4);
    // R8: hot again across the rising edge keeps the flag
    over_temp = 1'b1; cyc(2); txd_in = 1'b1; cyc(5);
    chk("R8", {3'b0, therm_fault}, 4'b0001);
    over_temp = 1'b0; cyc(4);
    txd_in = 1'b0; cyc(3); txd_in = 1'b1; cyc(5);
    chk("R8", {3'b0, therm_fault}, 4'b0);

    // R7: timer keeps running under thermal fault
    req = "R7";
    over_temp = 1'b1; txd_in = 1'b0; cyc(TMO + 6);
    chk("R7", {2'b0, tmo_fault, therm_fault}, 4'b0011);
    over_temp = 1'b0; cyc(3); txd_in = 1'b1; cyc(5);

    // R9: standby and low supply gate the driver, flags untouched
    req = "R9";
    txd_in = 1'b0; standby = 1'b1; cyc(5);
    chk("R9", {drv_en, drv_dom, 2'b0}, 4'b0);
    standby = 1'b0; pwr_ok = 1'b0; cyc(5);
    pwr_ok = 1'b1; cyc(2);
    txd_in = 1'b1; cyc(3);
    standby = 1'b1; txd_in = 1'b0; cyc(TMO + 5);
    chk("R9", {3'b0, tmo_fault}, 4'b0001);
    standby = 1'b0; txd_in = 1'b1; cyc(6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule